// File: doc/BRIEF.md
# Compressed Parcel Expander

The block takes one 16-bit compressed instruction parcel and rewrites it as the equivalent 32-bit base instruction word. It handles four compressed forms:

- a double-precision floating-point load;
- an add-immediate that writes back to its own source register;
- an add of a scaled immediate to the stack pointer;
- an unconditional jump.

Each form scatters its immediate bits across the parcel in its own order. The expander puts those bits back in order and rebuilds the immediate. It also widens the 3-bit short register fields onto registers 8 to 15.

A parcel whose two low bits are both 1 is not compressed. The block passes it through and flags it. Any other compressed encoding is flagged as illegal, and so is the reserved all-zero stack-add.

The result is registered by default, so the expanded word appears one clock after the parcel is presented. Setting `REG_OUT` to 0 makes the path purely combinational.

Top module: `cpx_expand`

## Requirements
- R1: While rst_ni is low, instr_o, illegal_o and full_o are all 0.
- R2: A parcel with bits[1:0]=00 and bits[15:13]=001 expands to a floating-point double load. The word is {12-bit zero-extended offset, base, 3'b011, dest, 7'b0000111}. The offset is {p[6:5], p[12:10], 3'b000}, giving 0 to 248. The base register is 8+p[9:7] and the dest register is 8+p[4:2].
- R3: A parcel with bits[1:0]=01 and bits[15:13]=000 expands to {imm12, r, 3'b000, r, 7'b0010011}. Here r=p[11:7], and imm12 is {p[12], p[6:2]} sign-extended from bit 5, giving -32 to +31.
- R4: A parcel with bits[1:0]=00, bits[15:13]=000 and a nonzero immediate expands to {imm12, 5'd2, 3'b000, 8+p[4:2], 7'b0010011}. The immediate is zero-extended and equals p[10:7]*64 + p[12:11]*16 + p[5]*8 + p[6]*4, giving 4 to 1020.
- R5: A parcel with bits[1:0]=00, bits[15:13]=000 and p[12:5]=0 (the all-zero parcel included) raises illegal_o, whatever p[4:2] holds.
- R6: A parcel with bits[1:0]=01 and bits[15:13]=101 expands to a jump-and-link with destination register 0. The word is {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'b1101111}. The offset is sign-extended from bit 11, with off[11]=p[12], off[10]=p[8], off[9:8]=p[10:9], off[7]=p[6], off[6]=p[7], off[5]=p[2], off[4]=p[11], off[3:1]=p[5:3] and off[0]=0.
- R7: A parcel with bits[1:0]=11 is not compressed. full_o is 1, illegal_o is 0 and instr_o is {16'h0000, parcel}.
- R8: Any other parcel with bits[1:0] not equal to 11 gives illegal_o=1 and instr_o=0. For every handled form illegal_o and full_o are 0.
- R9: With REG_OUT=1 the outputs reflect the parcel sampled at the previous rising clock edge. A change of parcel_i between edges does not reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| parcel_i | input | 16 | Instruction parcel to expand |
| instr_o | output | 32 | Expanded 32-bit instruction word, or 0 when illegal |
| illegal_o | output | 1 | Compressed parcel not supported or reserved |
| full_o | output | 1 | Parcel was already a full-width instruction (passed through) |

## Verification
The hardest cases are the immediate scrambles, because one wrong wire only shows up for offsets that set that particular bit. The bench therefore sweeps every legal offset of the load, add-immediate, stack-add and jump forms. It builds each parcel from the offset by scattering the bits itself, and compares the result against a word assembled directly from the unscrambled offset. The reserved stack-add is reached with zero immediate bits but a nonzero register field, as well as with the all-zero parcel. The registered-output latency is probed by changing the parcel in mid-cycle.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int PARCEL_W = 16;
  localparam int INSN_W   = 32;
  localparam int IMM_W    = 12;
  localparam int JOFF_W   = 21;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_FULL,
    FORM_LDFP,
    FORM_ADDIMM,
    FORM_SPADD,
    FORM_JUMP
  } form_e;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LDFP  = 7'b0000111;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [2:0] F3_ADD    = 3'b000;
  localparam logic [2:0] F3_DBL    = 3'b011;
  localparam logic [4:0] REG_SP    = 5'd2;
  localparam logic [4:0] REG_ZERO  = 5'd0;

  // short register field -> registers 8..15
  function automatic logic [4:0] prime_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
(
  input  logic [15:5] hi_i,
  input  logic [1:0]  quad_i,
  output form_e       form_o
);
  logic [2:0] f3;
  assign f3 = hi_i[15:13];

  always_comb begin
    form_o = FORM_NONE;
    if (quad_i == 2'b11) begin
      form_o = FORM_FULL;
    end else begin
      case ({quad_i, f3})
        5'b00_001: form_o = FORM_LDFP;
        5'b00_000: form_o = (hi_i[12:5] != '0) ? FORM_SPADD : FORM_NONE;
        5'b01_000: form_o = FORM_ADDIMM;
        5'b01_101: form_o = FORM_JUMP;
        default:   form_o = FORM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cpx_imm.sv
module cpx_imm
  import cpx_pkg::*;
(
  input  logic [12:2]       p_i,
  output logic [IMM_W-1:0]  imm_ldfp_o,
  output logic [IMM_W-1:0]  imm_add_o,
  output logic [IMM_W-1:0]  imm_sp_o,
  output logic [JOFF_W-1:0] off_jump_o
);
  logic [7:0]  ldfp;
  logic [5:0]  addv;
  logic [9:0]  spv;
  logic [11:0] jv;

  assign ldfp = {p_i[6:5], p_i[12:10], 3'b000};
  assign addv = {p_i[12], p_i[6:2]};
  assign spv  = {p_i[10:7], p_i[12:11], p_i[5], p_i[6], 2'b00};
  assign jv   = {p_i[12], p_i[8], p_i[10:9], p_i[6], p_i[7], p_i[2], p_i[11],
                 p_i[5:3], 1'b0};

  assign imm_ldfp_o = {{(IMM_W-8){1'b0}}, ldfp};
  assign imm_add_o  = {{(IMM_W-6){addv[5]}}, addv};
  assign imm_sp_o   = {{(IMM_W-10){1'b0}}, spv};
  assign off_jump_o = {{(JOFF_W-12){jv[11]}}, jv};
endmodule

// File: rtl/cpx_assemble.sv
module cpx_assemble
  import cpx_pkg::*;
(
  input  form_e             form_i,
  input  logic [15:0]       p_i,
  input  logic [IMM_W-1:0]  imm_ldfp_i,
  input  logic [IMM_W-1:0]  imm_add_i,
  input  logic [IMM_W-1:0]  imm_sp_i,
  input  logic [JOFF_W-1:0] off_jump_i,
  output logic [INSN_W-1:0] instr_o,
  output logic              illegal_o,
  output logic              full_o
);
  always_comb begin
    instr_o   = '0;
    illegal_o = 1'b0;
    full_o    = 1'b0;
    case (form_i)
      FORM_FULL: begin
        instr_o = {{(INSN_W-PARCEL_W){1'b0}}, p_i};
        full_o  = 1'b1;
      end
      FORM_LDFP:
        instr_o = {imm_ldfp_i, prime_reg(p_i[9:7]), F3_DBL, prime_reg(p_i[4:2]), OPC_LDFP};
      FORM_ADDIMM:
        instr_o = {imm_add_i, p_i[11:7], F3_ADD, p_i[11:7], OPC_OPIMM};
      FORM_SPADD:
        instr_o = {imm_sp_i, REG_SP, F3_ADD, prime_reg(p_i[4:2]), OPC_OPIMM};
      FORM_JUMP:
        instr_o = {off_jump_i[20], off_jump_i[10:1], off_jump_i[11], off_jump_i[19:12],
                   REG_ZERO, OPC_JAL};
      default:
        illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cpx_expand.sv
module cpx_expand
  import cpx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       parcel_i,
  output logic [31:0]       instr_o,
  output logic              illegal_o,
  output logic              full_o
);
  form_e              form;
  logic [IMM_W-1:0]   imm_ldfp, imm_add, imm_sp;
  logic [JOFF_W-1:0]  off_jump;
  logic [INSN_W-1:0]  instr_c;
  logic               illegal_c, full_c;

  cpx_decode u_dec (
    .hi_i   (parcel_i[15:5]),
    .quad_i (parcel_i[1:0]),
    .form_o (form)
  );

  cpx_imm u_imm (
    .p_i        (parcel_i[12:2]),
    .imm_ldfp_o (imm_ldfp),
    .imm_add_o  (imm_add),
    .imm_sp_o   (imm_sp),
    .off_jump_o (off_jump)
  );

  cpx_assemble u_asm (
    .form_i     (form),
    .p_i        (parcel_i),
    .imm_ldfp_i (imm_ldfp),
    .imm_add_i  (imm_add),
    .imm_sp_i   (imm_sp),
    .off_jump_i (off_jump),
    .instr_o    (instr_c),
    .illegal_o  (illegal_c),
    .full_o     (full_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        instr_o   <= '0;
        illegal_o <= 1'b0;
        full_o    <= 1'b0;
      end else begin
        instr_o   <= instr_c;
        illegal_o <= illegal_c;
        full_o    <= full_c;
      end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (instr_o == '0 && !illegal_o && !full_o));

    // R5
    sp_zero_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parcel_i[1:0] == 2'b00 && parcel_i[15:13] == 3'b000 && parcel_i[12:5] == '0)
      |=> illegal_o);

    // R7
    full_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parcel_i[1:0] == 2'b11)
      |=> (full_o && !illegal_o && instr_o[15:0] == $past(parcel_i) && instr_o[31:16] == '0));

    // R8
    illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> (instr_o == '0 && !full_o));

    // R6
    jump_link_x0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parcel_i[1:0] == 2'b01 && parcel_i[15:13] == 3'b101)
      |=> (instr_o[6:0] == OPC_JAL && instr_o[11:7] == '0 && instr_o[31] == $past(parcel_i[12])));

    // R3
    add_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parcel_i[1:0] == 2'b01 && parcel_i[15:13] == 3'b000)
      |=> (instr_o[31:25] == {7{$past(parcel_i[12])}} && instr_o[11:7] == instr_o[19:15]));

    // R2
    ldfp_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parcel_i[1:0] == 2'b00 && parcel_i[15:13] == 3'b001)
      |=> (instr_o[31:28] == '0 && instr_o[14:12] == F3_DBL && instr_o[2:0] == 3'b111));

    // R4
    sp_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parcel_i[1:0] == 2'b00 && parcel_i[15:13] == 3'b000 && parcel_i[12:5] != '0)
      |=> (instr_o[19:15] == REG_SP && instr_o[21:20] == 2'b00 && !illegal_o));
  end else begin : g_comb
    assign instr_o   = instr_c;
    assign illegal_o = illegal_c;
    assign full_o    = full_c;
  end
endmodule

// File: tb/tb_cpx_expand.sv
`timescale 1ns/1ps
module tb_cpx_expand;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] parcel_i = '0;
  logic [31:0] instr_o;
  logic        illegal_o, full_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  cpx_expand dut (
    .clk_i, .rst_ni, .parcel_i, .instr_o, .illegal_o, .full_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] itype(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  task automatic apply(input logic [15:0] p);
    parcel_i = p;
    @(posedge clk_i);
    #2;
  endtask

  task automatic t_reset;
    parcel_i = 16'h0003;
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1 instr", instr_o, 32'h0);
    chk("R1 illegal", {31'b0, illegal_o}, 32'h0);
    chk("R1 full", {31'b0, full_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_ldfp;
    logic [7:0] off;
    logic [2:0] rd, rs;
    for (int k = 0; k < 32; k++) begin
      off = 8'(k * 8);
      rd  = 3'(k);
      rs  = 3'(7 - k);
      apply({3'b001, off[5:3], rs, off[7:6], rd, 2'b00});
      chk("R2 ldfp", instr_o, itype({4'b0, off}, {2'b01, rs}, 3'b011, {2'b01, rd}, 7'b0000111));
      chk("R8 ldfp flags", {30'b0, illegal_o, full_o}, 32'h0);
    end
  endtask

  task automatic t_addimm;
    logic [5:0] v;
    logic [4:0] r;
    for (int i = -32; i < 32; i++) begin
      v = 6'(i);
      r = v[4:0] ^ 5'd7;
      apply({3'b000, v[5], r, v[4:0], 2'b01});
      chk("R3 addimm", instr_o, itype(12'(i), r, 3'b000, r, 7'b0010011));
    end
  endtask

  task automatic t_spadd;
    logic [9:0] o;
    logic [2:0] rd;
    for (int k = 4; k <= 1020; k += 4) begin
      o  = 10'(k);
      rd = 3'(k >> 2);
      apply({3'b000, o[5:4], o[9:6], o[2], o[3], rd, 2'b00});
      chk("R4 spadd", instr_o, itype({2'b0, o}, 5'd2, 3'b000, {2'b01, rd}, 7'b0010011));
    end
  endtask

  task automatic t_sp_zero;
    apply(16'h0000);
    chk("R5 zero parcel illegal", {31'b0, illegal_o}, 32'h1);
    chk("R5 zero parcel word", instr_o, 32'h0);
    apply(16'h0014);
    chk("R5 zero imm illegal", {31'b0, illegal_o}, 32'h1);
    chk("R5 zero imm word", instr_o, 32'h0);
  endtask

  task automatic t_jump;
    logic [11:0] o;
    logic [20:0] j;
    for (int k = -2048; k < 2048; k += 2) begin
      o = 12'(k);
      j = 21'(k);
      apply({3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01});
      chk("R6 jump", instr_o, {j[20], j[10:1], j[11], j[19:12], 5'd0, 7'b1101111});
    end
  endtask

  task automatic t_full;
    logic [15:0] vals [4] = '{16'h0003, 16'hffff, 16'h1237, 16'h80b3};
    foreach (vals[i]) begin
      apply(vals[i]);
      chk("R7 pass word", instr_o, {16'h0, vals[i]});
      chk("R7 flags", {30'b0, illegal_o, full_o}, 32'h1);
    end
  endtask

  task automatic t_other;
    logic [15:0] vals [5] = '{16'h0002, 16'h4505, 16'h4188, 16'h2001, 16'hE002};
    foreach (vals[i]) begin
      apply(vals[i]);
      chk("R8 word", instr_o, 32'h0);
      chk("R8 flags", {30'b0, illegal_o, full_o}, 32'h2);
    end
  endtask

  task automatic t_latency;
    apply(16'h0505);
    chk("R9 first", instr_o, itype(12'd1, 5'd10, 3'b000, 5'd10, 7'b0010011));
    parcel_i = 16'h0003;
    #2;
    chk("R9 held mid-cycle", instr_o, itype(12'd1, 5'd10, 3'b000, 5'd10, 7'b0010011));
    @(posedge clk_i);
    #2;
    chk("R9 next edge", instr_o, 32'h0000_0003);
  endtask

  initial begin
    #6;
    t_reset();
    t_ldfp();
    t_addimm();
    t_spadd();
    t_sp_zero();
    t_jump();
    t_full();
    t_other();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule